// File: doc/BRIEF.md
# SD Host Command Issue Front End

This block sits between a simple register bus and the command path of an SD host. Software writes argument words and then a command word. The block decides whether that command may go out, and if so it raises a command request toward the card side. It holds the request until the card side reports completion. It then stores the returned response and records completion and error events in two write-one-to-clear status registers. Each status register has its own enable register. An interrupt line is the OR of every status bit that is both set and enabled.

The issue gate has no power-enable condition, so a command can go out straight after reset. The register at the bottom of the map holds a second argument word rather than a transfer address. When a command asked for no response but the card answers anyway, the command completes cleanly and the answer is dropped. A card-present flag reads as set after power-up. A software reset clears it, and nothing sets it again. That flag never takes part in the interrupt.

Top module: `sdh_cmd_issue`

## Requirements
- R1: After `rst`, `cmd_req` and `irq` are 0, every register reads 0 except the present-state card flag (offset 0x24, bit 16), which reads 1, and the capability word (0x40), which reads `CAPS_VALUE`.
- R2: Offset 0x00 is a read/write secondary argument and offset 0x08 is a read/write primary argument. The primary argument drives `cmd_arg` for an issued command.
- R3: A command issues with no prior write anywhere else in the map. Writes to offset 0x28 have no effect, and that offset reads 0.
- R4: A command write (offset 0x0C) raises `cmd_req` on the next clock only if `sd_clk_on` is 1.
- R5: With the clock running, a command is blocked when (`data_inhibit` or `stopped`) is 1 and either the data-present bit (bit 5) is set or the response type (bits 1:0) is 11. Otherwise it issues. `cmd_index` comes from bits 13:8 and `cmd_rsp_type` from bits 1:0.
- R6: From issue until the first `card_done`, `cmd_req` and present-state bit 0 stay 1. Command writes during that time are ignored, both in the register and on the outputs.
- R7: Response type 00 means none, 01 a 136-bit response, 10 a 48-bit response and 11 a 48-bit response with busy. On completion, `card_rsp` is stored at offset 0x10 only for types other than 00. For type 00, any returned response is discarded and no error is raised.
- R8: For types 10 and 11, a returned response whose `card_rsp_idx` differs from the issued index sets error status bit 0 (offset 0x34), provided error enable bit 0 (offset 0x3C) is 1.
- R9: Completion sets normal status bit 0 (offset 0x30) only when normal enable bit 0 (offset 0x38) is 1. `irq` is 1 exactly when some status bit and its enable are both 1.
- R10: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R11: Writing 1 to bit 0 of offset 0x2C clears both arguments, the command word, the response, both status registers and any outstanding request. It also clears the card flag, which then stays 0 until `rst`. The enables and the capability word are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| sd_clk_on | input | 1 | SD clock running |
| data_inhibit | input | 1 | Data line busy |
| stopped | input | 1 | Transfer in stopped state |
| cmd_req | output | 1 | Command outstanding toward card side |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | DATA_W | Primary argument |
| cmd_rsp_type | output | 2 | Response type code |
| card_done | input | 1 | Card side completion pulse |
| card_rsp_present | input | 1 | Card returned a response |
| card_rsp_idx | input | 6 | Index carried in that response |
| card_rsp | input | DATA_W | Response word |
| irq | output | 1 | Interrupt |

## Verification
Register reads are combinational, so a read value is checked in the cycle its address is driven. A write takes effect at the clock edge that samples it. `cmd_req`, the command outputs, the stored response and the status bits therefore change one edge after the command write or the `card_done` pulse. `irq` follows the status in that same cycle. The bench drives every stimulus just after a falling edge and samples just after the next falling edge. This places each check one rising edge after its cause, which is where every result is due.

// File: rtl/sdh_cmd_pkg.sv
package sdh_cmd_pkg;

    typedef enum logic [1:0] {
        RSP_NONE = 2'b00,
        RSP_136  = 2'b01,
        RSP_48   = 2'b10,
        RSP_48B  = 2'b11
    } rsp_kind_e;

    typedef struct packed {
        logic [5:0] index;
        logic       data_present;
        rsp_kind_e  rsp;
    } cmd_word_t;

    localparam int OFF_ARG2    = 'h00;
    localparam int OFF_ARG1    = 'h08;
    localparam int OFF_CMD     = 'h0C;
    localparam int OFF_RESP    = 'h10;
    localparam int OFF_PRESENT = 'h24;
    localparam int OFF_HOSTCTL = 'h28;
    localparam int OFF_CTRL    = 'h2C;
    localparam int OFF_NSTAT   = 'h30;
    localparam int OFF_ESTAT   = 'h34;
    localparam int OFF_NEN     = 'h38;
    localparam int OFF_EEN     = 'h3C;
    localparam int OFF_CAPS    = 'h40;

    localparam int SRST_BIT      = 0;
    localparam int NSTAT_DONE    = 0;
    localparam int ESTAT_IDX     = 0;
    localparam int PRES_CMD_INH  = 0;
    localparam int PRES_DATA_INH = 1;
    localparam int PRES_CARD     = 16;

    function automatic cmd_word_t cmd_decode(input logic [31:0] w);
        cmd_word_t c;
        c.index        = w[13:8];
        c.data_present = w[5];
        c.rsp          = rsp_kind_e'(w[1:0]);
        return c;
    endfunction

    function automatic logic [31:0] cmd_encode(input cmd_word_t c);
        logic [31:0] w;
        w        = '0;
        w[13:8]  = c.index;
        w[5]     = c.data_present;
        w[1:0]   = c.rsp;
        return w;
    endfunction

    function automatic logic rsp_has_index(input rsp_kind_e k);
        return (k == RSP_48) || (k == RSP_48B);
    endfunction

endpackage

// File: rtl/sdh_issue_gate.sv
module sdh_issue_gate
    import sdh_cmd_pkg::*;
(
    input  logic      clk_run,
    input  logic      data_inhibit,
    input  logic      stopped,
    input  cmd_word_t cmd,
    output logic      allow
);
    logic line_busy;
    logic needs_line;

    always_comb begin
        line_busy  = data_inhibit | stopped;
        needs_line = cmd.data_present | (cmd.rsp == RSP_48B);
        allow      = clk_run & ~(line_busy & needs_line);
    end
endmodule

// File: rtl/sdh_int_status.sv
module sdh_int_status #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_all,
    input  logic [W-1:0] set_req,
    input  logic         w1c_we,
    input  logic [W-1:0] w1c_mask,
    input  logic         en_we,
    input  logic [W-1:0] en_wdata,
    output logic [W-1:0] stat,
    output logic [W-1:0] en,
    output logic         irq_part
);
    logic [W-1:0] clr_vec;

    always_comb begin
        clr_vec  = w1c_we ? w1c_mask : '0;
        irq_part = |(stat & en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            en   <= '0;
        end else begin
            if (en_we) en <= en_wdata;
            if (clr_all) stat <= '0;
            else         stat <= (stat & ~clr_vec) | (set_req & en);
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_chk
        assert_set_needs_enable_R9: assert property (@(posedge clk) disable iff (rst)
            $rose(stat[i]) |-> $past(en[i]));
        assert_w1c_clears_R10: assert property (@(posedge clk) disable iff (rst)
            (w1c_we && w1c_mask[i] && !set_req[i]) |=> !stat[i]);
    end
endmodule

// File: rtl/sdh_cmd_issue.sv
module sdh_cmd_issue
    import sdh_cmd_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int          DATA_W     = 32,
    parameter int          STAT_W     = 16,
    parameter logic [31:0] CAPS_VALUE = 32'h0000_3C80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sd_clk_on,
    input  logic              data_inhibit,
    input  logic              stopped,
    output logic              cmd_req,
    output logic [5:0]        cmd_index,
    output logic [DATA_W-1:0] cmd_arg,
    output logic [1:0]        cmd_rsp_type,
    input  logic              card_done,
    input  logic              card_rsp_present,
    input  logic [5:0]        card_rsp_idx,
    input  logic [DATA_W-1:0] card_rsp,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_ARG2    = ADDR_W'(OFF_ARG2);
    localparam logic [ADDR_W-1:0] A_ARG1    = ADDR_W'(OFF_ARG1);
    localparam logic [ADDR_W-1:0] A_CMD     = ADDR_W'(OFF_CMD);
    localparam logic [ADDR_W-1:0] A_RESP    = ADDR_W'(OFF_RESP);
    localparam logic [ADDR_W-1:0] A_PRESENT = ADDR_W'(OFF_PRESENT);
    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_NSTAT   = ADDR_W'(OFF_NSTAT);
    localparam logic [ADDR_W-1:0] A_ESTAT   = ADDR_W'(OFF_ESTAT);
    localparam logic [ADDR_W-1:0] A_NEN     = ADDR_W'(OFF_NEN);
    localparam logic [ADDR_W-1:0] A_EEN     = ADDR_W'(OFF_EEN);
    localparam logic [ADDR_W-1:0] A_CAPS    = ADDR_W'(OFF_CAPS);

    logic [DATA_W-1:0] arg1_q, arg2_q, resp_q;
    cmd_word_t         cmd_q, cmd_new;
    logic              busy_q, card_ins_q;
    logic              soft_rst, cmd_wr, gate_ok, done_evt;
    logic [STAT_W-1:0] norm_set, err_set, nstat, estat, nen, een;
    logic              irq_n, irq_e;

    always_comb begin
        soft_rst = bus_we && (bus_addr == A_CTRL) && bus_wdata[SRST_BIT];
        cmd_wr   = bus_we && (bus_addr == A_CMD) && !busy_q;
        cmd_new  = cmd_decode(32'(bus_wdata));
        done_evt = busy_q && card_done && !soft_rst;
        norm_set = '0;
        err_set  = '0;
        norm_set[NSTAT_DONE] = done_evt;
        err_set[ESTAT_IDX]   = done_evt && card_rsp_present &&
                               rsp_has_index(cmd_q.rsp) &&
                               (card_rsp_idx != cmd_q.index);
    end

    sdh_issue_gate u_gate (
        .clk_run      (sd_clk_on),
        .data_inhibit (data_inhibit),
        .stopped      (stopped),
        .cmd          (cmd_new),
        .allow        (gate_ok)
    );

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            arg1_q     <= '0;
            arg2_q     <= '0;
            resp_q     <= '0;
            cmd_q      <= '0;
            busy_q     <= 1'b0;
            card_ins_q <= rst;
        end else begin
            if (bus_we && bus_addr == A_ARG1) arg1_q <= bus_wdata;
            if (bus_we && bus_addr == A_ARG2) arg2_q <= bus_wdata;
            if (cmd_wr) begin
                cmd_q <= cmd_new;
                if (gate_ok) busy_q <= 1'b1;
            end
            if (done_evt) begin
                busy_q <= 1'b0;
                if (cmd_q.rsp != RSP_NONE && card_rsp_present) resp_q <= card_rsp;
            end
        end
    end

    sdh_int_status #(.W(STAT_W)) u_norm (
        .clk      (clk),
        .rst      (rst),
        .clr_all  (soft_rst),
        .set_req  (norm_set),
        .w1c_we   (bus_we && bus_addr == A_NSTAT),
        .w1c_mask (bus_wdata[STAT_W-1:0]),
        .en_we    (bus_we && bus_addr == A_NEN),
        .en_wdata (bus_wdata[STAT_W-1:0]),
        .stat     (nstat),
        .en       (nen),
        .irq_part (irq_n)
    );

    sdh_int_status #(.W(STAT_W)) u_err (
        .clk      (clk),
        .rst      (rst),
        .clr_all  (soft_rst),
        .set_req  (err_set),
        .w1c_we   (bus_we && bus_addr == A_ESTAT),
        .w1c_mask (bus_wdata[STAT_W-1:0]),
        .en_we    (bus_we && bus_addr == A_EEN),
        .en_wdata (bus_wdata[STAT_W-1:0]),
        .stat     (estat),
        .en       (een),
        .irq_part (irq_e)
    );

    always_comb begin
        irq          = irq_n | irq_e;
        cmd_req      = busy_q;
        cmd_index    = cmd_q.index;
        cmd_arg      = arg1_q;
        cmd_rsp_type = cmd_q.rsp;
        bus_rdata    = '0;
        case (bus_addr)
            A_ARG2:    bus_rdata = arg2_q;
            A_ARG1:    bus_rdata = arg1_q;
            A_CMD:     bus_rdata = DATA_W'(cmd_encode(cmd_q));
            A_RESP:    bus_rdata = resp_q;
            A_PRESENT: begin
                bus_rdata[PRES_CMD_INH]  = busy_q;
                bus_rdata[PRES_DATA_INH] = data_inhibit;
                bus_rdata[PRES_CARD]     = card_ins_q;
            end
            A_NSTAT:   bus_rdata = DATA_W'(nstat);
            A_ESTAT:   bus_rdata = DATA_W'(estat);
            A_NEN:     bus_rdata = DATA_W'(nen);
            A_EEN:     bus_rdata = DATA_W'(een);
            A_CAPS:    bus_rdata = DATA_W'(CAPS_VALUE);
            default:   bus_rdata = '0;
        endcase
    end

    assert_issue_needs_clock_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_req) |-> $past(sd_clk_on));
    assert_issue_gate_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_req) |-> !(($past(data_inhibit) || $past(stopped)) &&
                             (cmd_q.data_present || cmd_q.rsp == RSP_48B)));
    assert_hold_while_busy_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && !card_done && !soft_rst) |=> (cmd_req && $stable(cmd_index)));
    assert_no_err_for_none_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && card_done && cmd_q.rsp == RSP_NONE) |=> !$rose(estat[ESTAT_IDX]));
    assert_card_flag_never_rises_R11: assert property (@(posedge clk) disable iff (rst)
        !$rose(card_ins_q));
endmodule

// File: tb/sdh_cmd_issue_bench.sv
module sdh_cmd_issue_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sd_clk_on = 1'b1, data_inhibit = 1'b0, stopped = 1'b0;
    logic        cmd_req;
    logic [5:0]  cmd_index;
    logic [31:0] cmd_arg;
    logic [1:0]  cmd_rsp_type;
    logic        card_done = 1'b0, card_rsp_present = 1'b0;
    logic [5:0]  card_rsp_idx = '0;
    logic [31:0] card_rsp = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    localparam logic [31:0] CAPS = 32'h0000_3C80;

    always #5 clk = ~clk;

    sdh_cmd_issue u_sdh_cmd_issue (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sd_clk_on(sd_clk_on),
        .data_inhibit(data_inhibit), .stopped(stopped), .cmd_req(cmd_req),
        .cmd_index(cmd_index), .cmd_arg(cmd_arg), .cmd_rsp_type(cmd_rsp_type),
        .card_done(card_done), .card_rsp_present(card_rsp_present),
        .card_rsp_idx(card_rsp_idx), .card_rsp(card_rsp), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_cmd(input logic present, input logic [5:0] idx, input logic [31:0] d);
        @(negedge clk);
        card_done = 1'b1; card_rsp_present = present; card_rsp_idx = idx; card_rsp = d;
        @(negedge clk);
        card_done = 1'b0; card_rsp_present = 1'b0;
    endtask

    function automatic logic [31:0] cmdw(input logic [5:0] idx, input logic dp, input logic [1:0] rsp);
        return {18'b0, idx, 2'b0, dp, 3'b0, rsp};
    endfunction

    // {clk_on, data_inhibit, stopped, data_present, rsp[1:0], expect_issue}
    localparam logic [6:0] VEC [8] = '{
        7'b1_0_0_0_10_1,
        7'b0_0_0_0_10_0,
        7'b1_1_0_0_10_1,
        7'b1_1_0_1_10_0,
        7'b1_0_1_0_11_0,
        7'b1_0_1_0_01_1,
        7'b1_0_0_1_11_1,
        7'b1_1_1_0_00_1
    };

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [31:0] exp_resp;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 cmd_req", {31'b0, cmd_req}, 0);
        check("R1 irq", {31'b0, irq}, 0);
        rd(8'h24, r); check("R1 present card flag", r, 32'h0001_0000);
        rd(8'h08, r); check("R1 arg1", r, 0);
        rd(8'h30, r); check("R1 nstat", r, 0);
        rd(8'h40, r); check("R1 caps", r, CAPS);

        // R2 argument registers
        wr(8'h00, 32'hA5A5_0017); wr(8'h08, 32'h1234_5678);
        rd(8'h00, r); check("R2 arg2 readback", r, 32'hA5A5_0017);
        rd(8'h08, r); check("R2 arg1 readback", r, 32'h1234_5678);
        check("R2 cmd_arg", cmd_arg, 32'h1234_5678);

        wr(8'h38, 32'h1); wr(8'h3C, 32'h1);

        // R3 R4 R5 vector walk; first vector issues with no power write
        exp_resp = 0;
        for (int i = 0; i < 8; i++) begin
            logic [6:0] v;
            logic [5:0] idx;
            v = VEC[i];
            idx = 6'(i + 1);
            @(negedge clk);
            sd_clk_on = v[6]; data_inhibit = v[5]; stopped = v[4];
            wr(8'h0C, cmdw(idx, v[3], v[2:1]));
            check($sformatf("R3 R4 R5 vec %0d cmd_req", i), {31'b0, cmd_req}, {31'b0, v[0]});
            if (v[0]) begin
                check($sformatf("R5 vec %0d index", i), {26'b0, cmd_index}, {26'b0, idx});
                check($sformatf("R5 vec %0d rsp type", i), {30'b0, cmd_rsp_type}, {30'b0, v[2:1]});
                finish_cmd(1'b1, idx, 32'hC0DE_0000 + i);
                if (v[2:1] != 2'b00) exp_resp = 32'hC0DE_0000 + i;
                check($sformatf("R9 vec %0d done status", i), {31'b0, irq}, 1);
                rd(8'h10, r); check($sformatf("R7 vec %0d resp", i), r, exp_resp);
                rd(8'h34, r); check($sformatf("R7 vec %0d no error", i), r, 0);
                wr(8'h30, 32'h1);
            end
        end
        @(negedge clk);
        sd_clk_on = 1'b1; data_inhibit = 1'b0; stopped = 1'b0;

        // R3 host-control area write is ignored
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h28, r); check("R3 hostctl reads zero", r, 0);

        // R6 busy hold and ignored command write
        wr(8'h0C, cmdw(6'd17, 1'b0, 2'b10));
        rd(8'h24, r); check("R6 inhibit set", r & 32'h1, 1);
        wr(8'h0C, cmdw(6'd40, 1'b0, 2'b01));
        check("R6 index held", {26'b0, cmd_index}, 17);
        rd(8'h0C, r); check("R6 cmd reg held", r, cmdw(6'd17, 1'b0, 2'b10));
        check("R6 req held", {31'b0, cmd_req}, 1);

        // R8 index mismatch on 48-bit
        finish_cmd(1'b1, 6'd18, 32'hBEEF_0001);
        rd(8'h24, r); check("R6 inhibit cleared", r & 32'h1, 0);
        rd(8'h34, r); check("R8 index error", r, 1);
        // R10 write-0 keeps, write-1 clears
        wr(8'h34, 32'h0);
        rd(8'h34, r); check("R10 write zero keeps", r, 1);
        wr(8'h30, 32'h1); wr(8'h34, 32'h1);
        rd(8'h34, r); check("R10 write one clears", r, 0);
        check("R9 irq low when clear", {31'b0, irq}, 0);

        // R7 none type, mismatched response discarded
        wr(8'h0C, cmdw(6'd23, 1'b0, 2'b00));
        finish_cmd(1'b1, 6'd3, 32'hDEAD_DEAD);
        rd(8'h10, r); check("R7 response discarded", r, 32'hBEEF_0001);
        rd(8'h34, r); check("R7 no index error", r, 0);
        rd(8'h30, r); check("R7 completes", r, 1);
        wr(8'h30, 32'h1);

        // R9 disabled completion is not recorded
        wr(8'h38, 32'h0);
        wr(8'h0C, cmdw(6'd5, 1'b0, 2'b10));
        finish_cmd(1'b1, 6'd5, 32'h1);
        rd(8'h30, r); check("R9 masked status", r, 0);
        check("R9 masked irq", {31'b0, irq}, 0);
        wr(8'h38, 32'h1);

        // R11 software reset
        wr(8'h0C, cmdw(6'd9, 1'b0, 2'b10));
        finish_cmd(1'b1, 6'd9, 32'h77);
        wr(8'h0C, cmdw(6'd10, 1'b0, 2'b10));
        wr(8'h2C, 32'h1);
        check("R11 request dropped", {31'b0, cmd_req}, 0);
        rd(8'h00, r); check("R11 arg2 cleared", r, 0);
        rd(8'h08, r); check("R11 arg1 cleared", r, 0);
        rd(8'h0C, r); check("R11 cmd cleared", r, 0);
        rd(8'h10, r); check("R11 resp cleared", r, 0);
        rd(8'h30, r); check("R11 nstat cleared", r, 0);
        rd(8'h24, r); check("R11 card flag cleared", r, 0);
        rd(8'h38, r); check("R11 enable kept", r, 1);
        rd(8'h40, r); check("R11 caps kept", r, CAPS);
        wr(8'h0C, cmdw(6'd2, 1'b0, 2'b01));
        finish_cmd(1'b1, 6'd2, 32'h5);
        rd(8'h24, r); check("R11 card flag stays clear", r, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule